// File: doc/BRIEF.md
# Sector Program Sequencer with Region Write Protection

This block sits behind a serial memory front-end that has already decoded the instructions. It receives three kinds of request: setting the write-enable latch, programming one sector of the array, and writing the status register. It also receives the data bytes that follow a request and a pulse when chip select is released. Array data is collected in a sector-sized buffer. Nothing is written unless chip select is released exactly on the byte boundary after the last byte of a full sector.

At release time the block makes its protection decision. It looks at the write-enable latch, the nonvolatile protect-enable bit, the external protect pin and the two region-lock bits. An accepted write starts a busy period of fixed length. During that period the status word reports a busy flag, the buffered bytes are copied into the array one per cycle, and new requests are ignored. When the busy period ends, or when a write is refused, the latch is cleared. The array has a registered read port so that its contents can be observed.

Status word layout: bit 0 busy, bit 1 write-enable latch, bits 3:2 region lock, bit 7 protect-enable, bits 6:4 read as 0. In the region lock field, 00 locks nothing, 01 locks the top quarter of the sectors, 10 locks the top half and 11 locks every sector.

Top module: `sector_prog_seq`

## Requirements
- R1: After reset the status word is 8'h00.
- R2: With the latch clear (status bit 1 = 0), neither a sector program nor a status write changes anything.
- R3: An enable request while idle sets status bit 1 at the next clock edge.
- R4: Hardware protection is active when prot_pin is 0 and status bit 7 is 1, sampled in the cycle of the cs_rise pulse. A status write under hardware protection is refused and clears the latch. With prot_pin at 1, the status write is accepted.
- R5: A sector inside the region selected by status bits 3:2 (00 none, 01 top quarter, 10 top half, 11 all) is never programmed and its rejection clears the latch. Sectors outside that region stay programmable even under hardware protection.
- R6: An array write commits only when cs_rise arrives with cs_aligned = 1 after exactly SEC_BYTES data bytes. With 31 bytes, with 33 bytes, or with an unaligned release, the array is unchanged and the latch keeps its value.
- R7: Byte k of a committed sector lands at sector base + k. The address bits below the sector index in prog_addr are ignored.
- R8: An accepted status write stores data bit 7 and data bits 3:2. Data bits 0, 1, 4, 5 and 6 have no effect.
- R9: Status bit 0 is 1 for exactly BUSY_CYC cycles after an accepted commit. When it drops, the latch is clear.
- R10: While status bit 0 is 1, enable, program and status-write requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| en_req | input | 1 | pulse: set write-enable latch |
| prog_req | input | 1 | pulse: begin sector program |
| prog_addr | input | ADDR_W | start address of the sector program |
| sr_req | input | 1 | pulse: begin status write |
| byte_valid | input | 1 | pulse: one data byte on byte_data |
| byte_data | input | 8 | data byte |
| cs_rise | input | 1 | pulse: chip select released |
| cs_aligned | input | 1 | release fell on a byte boundary |
| prot_pin | input | 1 | protect pin, low asserts protection |
| rd_addr | input | ADDR_W | array read address |
| rd_data | output | 8 | array read data, one cycle latency |
| status | output | 8 | status word |

## Verification
Two things can happen in the same cycle: the commit decision on cs_rise and a change on the protect pin. The bench provokes this by changing prot_pin in exactly the cycle that carries cs_rise during a status write, once toward protection and once away from it. It judges the result by reading the status word after the decision cycle, expecting a refusal in the first case and an accepted write in the second. A second overlap, requests arriving while the busy copy is running, is judged from the latch, the lock bits and the array contents once busy drops.

// File: rtl/spq_pkg.sv
package spq_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_ARR  = 2'd1,
    S_SR   = 2'd2,
    S_BUSY = 2'd3
  } spq_state_t;
endpackage

// File: rtl/spq_gate.sv
module spq_gate #(
  parameter int SEC_W = 3
) (
  input  logic             latch,
  input  logic             pe_bit,
  input  logic             pin,
  input  logic [1:0]       lock_sel,
  input  logic [SEC_W-1:0] sec,
  output logic             arr_ok,
  output logic             sr_ok
);
  logic locked;
  logic hw_prot;

  always_comb begin
    case (lock_sel)
      2'b00:   locked = 1'b0;
      2'b01:   locked = &sec[SEC_W-1:SEC_W-2];
      2'b10:   locked = sec[SEC_W-1];
      default: locked = 1'b1;
    endcase
  end

  assign hw_prot = pe_bit & ~pin;
  assign arr_ok  = latch & ~locked;
  assign sr_ok   = latch & ~hw_prot;
endmodule

// File: rtl/spq_hold.sv
module spq_hold #(
  parameter int BYTES = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [7:0]       wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [7:0]       rdata
);
  logic [7:0] hold_q [BYTES];

  always_ff @(posedge clk) begin
    if (we) hold_q[widx] <= wdata;
  end

  assign rdata = hold_q[ridx];
endmodule

// File: rtl/spq_array.sv
module spq_array #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [2**AW];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sector_prog_seq.sv
module sector_prog_seq #(
  parameter int ADDR_W    = 8,
  parameter int SEC_BYTES = 32,
  parameter int BUSY_CYC  = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_req,
  input  logic              prog_req,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic              sr_req,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              cs_rise,
  input  logic              cs_aligned,
  input  logic              prot_pin,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic [7:0]        status
);
  import spq_pkg::*;

  localparam int IDX_W    = $clog2(SEC_BYTES);
  localparam int SEC_W    = ADDR_W - IDX_W;
  localparam int CNT_W    = $clog2(SEC_BYTES + 2);
  localparam int BUSY_EFF = (BUSY_CYC < SEC_BYTES) ? SEC_BYTES : BUSY_CYC;
  localparam int BW       = $clog2(BUSY_EFF + 1);

  spq_state_t       state;
  logic [CNT_W-1:0] byte_cnt;
  logic [SEC_W-1:0] sec_q;
  logic [BW-1:0]    busy_cnt;
  logic             is_arr_q, pip_q, latch_q, pe_q;
  logic [1:0]       lock_q, sr_lock_q;
  logic             sr_pe_q;
  logic             arr_ok, sr_ok;
  logic             hold_we, mem_we;
  logic [7:0]       hold_rd;
  logic             unused_lo;

  assign unused_lo = ^prog_addr[IDX_W-1:0];

  spq_gate #(.SEC_W(SEC_W)) u_gate (
    .latch(latch_q), .pe_bit(pe_q), .pin(prot_pin), .lock_sel(lock_q),
    .sec(sec_q), .arr_ok(arr_ok), .sr_ok(sr_ok)
  );

  assign hold_we = (state == S_ARR) && byte_valid && !cs_rise &&
                   (byte_cnt < CNT_W'(SEC_BYTES));

  spq_hold #(.BYTES(SEC_BYTES), .IDX_W(IDX_W)) u_hold (
    .clk(clk), .we(hold_we), .widx(byte_cnt[IDX_W-1:0]), .wdata(byte_data),
    .ridx(busy_cnt[IDX_W-1:0]), .rdata(hold_rd)
  );

  assign mem_we = (state == S_BUSY) && is_arr_q && (busy_cnt < BW'(SEC_BYTES));

  spq_array #(.AW(ADDR_W), .DW(8)) u_array (
    .clk(clk), .we(mem_we), .waddr({sec_q, busy_cnt[IDX_W-1:0]}),
    .wdata(hold_rd), .raddr(rd_addr), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      byte_cnt  <= '0;
      sec_q     <= '0;
      busy_cnt  <= '0;
      is_arr_q  <= 1'b0;
      pip_q     <= 1'b0;
      latch_q   <= 1'b0;
      pe_q      <= 1'b0;
      lock_q    <= 2'b00;
      sr_lock_q <= 2'b00;
      sr_pe_q   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          byte_cnt <= '0;
          if (prog_req) begin
            state <= S_ARR;
            sec_q <= prog_addr[ADDR_W-1:IDX_W];
          end else if (sr_req) begin
            state <= S_SR;
          end else if (en_req) begin
            latch_q <= 1'b1;
          end
        end
        S_ARR: begin
          if (cs_rise) begin
            state <= S_IDLE;
            if (byte_cnt == CNT_W'(SEC_BYTES) && cs_aligned) begin
              if (arr_ok) begin
                state    <= S_BUSY;
                pip_q    <= 1'b1;
                is_arr_q <= 1'b1;
                busy_cnt <= '0;
              end else begin
                latch_q <= 1'b0;
              end
            end
          end else if (byte_valid && byte_cnt <= CNT_W'(SEC_BYTES)) begin
            byte_cnt <= byte_cnt + 1'b1;
          end
        end
        S_SR: begin
          if (cs_rise) begin
            state <= S_IDLE;
            if (byte_cnt == CNT_W'(1) && cs_aligned) begin
              if (sr_ok) begin
                lock_q   <= sr_lock_q;
                pe_q     <= sr_pe_q;
                state    <= S_BUSY;
                pip_q    <= 1'b1;
                is_arr_q <= 1'b0;
                busy_cnt <= '0;
              end else begin
                latch_q <= 1'b0;
              end
            end
          end else if (byte_valid) begin
            if (byte_cnt == '0) begin
              sr_lock_q <= byte_data[3:2];
              sr_pe_q   <= byte_data[7];
            end
            if (byte_cnt < CNT_W'(2)) byte_cnt <= byte_cnt + 1'b1;
          end
        end
        default: begin
          if (busy_cnt == BW'(BUSY_EFF - 1)) begin
            state   <= S_IDLE;
            pip_q   <= 1'b0;
            latch_q <= 1'b0;
          end else begin
            busy_cnt <= busy_cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign status = {pe_q, 3'b000, lock_q, latch_q, pip_q};

  // R9
  mem_we_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> pip_q);

  // R6
  commit_cs_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pip_q) |-> $past(cs_rise && cs_aligned));

  // R4
  sr_prot_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(pe_q) |-> $past(latch_q && (prot_pin || !pe_q)));

  // R9
  latch_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pip_q) |-> !latch_q);

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    pip_q |=> ($stable(lock_q) && $stable(pe_q)));
endmodule

// File: tb/sim_sector_prog_seq.sv
module sim_sector_prog_seq;
  localparam int AW = 8;
  localparam int BUSY = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_req = 0, prog_req = 0, sr_req = 0, byte_valid = 0;
  logic cs_rise = 0, cs_aligned = 0, prot_pin = 1;
  logic [AW-1:0] prog_addr = '0, rd_addr = '0;
  logic [7:0] byte_data = '0, rd_data, status;

  int total = 0, fails = 0;
  bit done = 0;
  logic [7:0] model [256];

  always #5 clk = ~clk;

  sector_prog_seq #(.ADDR_W(AW), .SEC_BYTES(32), .BUSY_CYC(BUSY)) u0 (
    .clk(clk), .rst(rst), .en_req(en_req), .prog_req(prog_req),
    .prog_addr(prog_addr), .sr_req(sr_req), .byte_valid(byte_valid),
    .byte_data(byte_data), .cs_rise(cs_rise), .cs_aligned(cs_aligned),
    .prot_pin(prot_pin), .rd_addr(rd_addr), .rd_data(rd_data), .status(status)
  );

  // bl, pe, pin, en, sector, nbytes, aligned, expect_write
  localparam logic [15:0] VEC [11] = '{
    {2'b00, 1'b0, 1'b1, 1'b1, 3'd0, 6'd32, 1'b1, 1'b1},
    {2'b00, 1'b0, 1'b1, 1'b0, 3'd1, 6'd32, 1'b1, 1'b0},
    {2'b01, 1'b0, 1'b1, 1'b1, 3'd6, 6'd32, 1'b1, 1'b0},
    {2'b01, 1'b0, 1'b1, 1'b1, 3'd5, 6'd32, 1'b1, 1'b1},
    {2'b10, 1'b0, 1'b1, 1'b1, 3'd4, 6'd32, 1'b1, 1'b0},
    {2'b10, 1'b1, 1'b0, 1'b1, 3'd3, 6'd32, 1'b1, 1'b1},
    {2'b11, 1'b0, 1'b1, 1'b1, 3'd0, 6'd32, 1'b1, 1'b0},
    {2'b00, 1'b0, 1'b1, 1'b1, 3'd2, 6'd31, 1'b1, 1'b0},
    {2'b00, 1'b0, 1'b1, 1'b1, 3'd2, 6'd33, 1'b1, 1'b0},
    {2'b00, 1'b0, 1'b1, 1'b1, 3'd2, 6'd32, 1'b0, 1'b0},
    {2'b00, 1'b0, 1'b1, 1'b1, 3'd7, 6'd32, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_en();
    en_req = 1; step(); en_req = 0;
  endtask

  task automatic do_prog(input logic [7:0] addr, input int nb, input logic al,
                         input logic [7:0] base);
    prog_req = 1; prog_addr = addr; step(); prog_req = 0;
    for (int i = 0; i < nb; i++) begin
      byte_valid = 1; byte_data = base + 8'(i); step();
    end
    byte_valid = 0;
    cs_rise = 1; cs_aligned = al; step(); cs_rise = 0; cs_aligned = 0;
  endtask

  task automatic do_sr(input logic [7:0] d, input logic pin_at_cs);
    sr_req = 1; step(); sr_req = 0;
    byte_valid = 1; byte_data = d; step(); byte_valid = 0;
    cs_rise = 1; cs_aligned = 1; prot_pin = pin_at_cs; step();
    cs_rise = 0; cs_aligned = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (status[0] === 1'b1 && n < 200) begin step(); n++; end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    rd_addr = a; step(); d = rd_data;
  endtask

  task automatic set_status(input logic [1:0] bl, input logic pe);
    prot_pin = 1; do_en();
    do_sr({pe, 3'b111, bl, 2'b11}, 1'b1);
    wait_idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) step();
    rst = 0; step();
    // R1 reset state
    chk("R1", status, 8'h00);

    // prefill every sector with a known pattern
    for (int s = 0; s < 8; s++) begin
      do_en();
      do_prog(8'(s * 32), 32, 1'b1, 8'(8'h80 + s * 2));
      wait_idle();
      for (int i = 0; i < 32; i++) model[s * 32 + i] = 8'(8'h80 + s * 2 + i);
    end
    rd(8'd0, d);  chk("R7", d, model[0]);
    rd(8'd255, d); chk("R7", d, model[255]);

    // R3 latch set, R8 reserved data bits ignored
    do_en(); chk("R3", status[1], 1'b1);
    do_sr(8'b0111_1011, 1'b1);
    wait_idle();
    chk("R8", status, 8'h08);
    set_status(2'b00, 1'b0);
    chk("R8", status, 8'h00);

    // R2 status write without latch
    do_sr(8'h8C, 1'b1); wait_idle();
    chk("R2", status, 8'h00);

    // R9 busy duration and latch clear
    begin
      int cnt = 0;
      do_en();
      do_prog(8'd32, 32, 1'b1, 8'h11);
      for (int i = 0; i < 32; i++) model[32 + i] = 8'(8'h11 + i);
      chk("R9", status[0], 1'b1);
      while (status[0] === 1'b1 && cnt < 200) begin cnt++; step(); end
      chk("R9", cnt, BUSY);
      chk("R9", status[1], 1'b0);
      rd(8'd63, d); chk("R7", d, model[63]);
    end

    // R10 requests during busy ignored
    do_en();
    do_prog(8'd64, 32, 1'b1, 8'h22);
    for (int i = 0; i < 32; i++) model[64 + i] = 8'(8'h22 + i);
    do_en();
    do_sr(8'h8C, 1'b1);
    do_prog(8'd96, 32, 1'b1, 8'h55);
    wait_idle();
    chk("R10", status, 8'h00);
    rd(8'd96, d);  chk("R10", d, model[96]);
    rd(8'd127, d); chk("R10", d, model[127]);

    // R4 pin change in the commit cycle
    set_status(2'b00, 1'b1);
    chk("R4", status, 8'h80);
    prot_pin = 1; do_en();
    do_sr(8'h04, 1'b0); step();
    chk("R4", status, 8'h80);
    prot_pin = 0; do_en();
    do_sr(8'h04, 1'b1); wait_idle();
    chk("R4", status, 8'h04);
    set_status(2'b00, 1'b0);

    // vector table: protection, lock regions, commit framing
    for (int k = 0; k < 11; k++) begin
      logic [15:0] v;
      logic [2:0] sec;
      logic [7:0] base, exp_latch;
      int nb;
      string rq;
      v = VEC[k];
      sec = v[10:8];
      nb = int'(v[7:2]);
      base = 8'(k * 16 + 3);
      if (nb != 32 || !v[1]) rq = "R6";
      else if (!v[11]) rq = "R2";
      else if (!v[0]) rq = "R5";
      else rq = "R7";
      set_status(v[15:14], v[13]);
      prot_pin = v[12];
      if (v[11]) do_en();
      do_prog({sec, 5'd5}, nb, v[1], base);
      wait_idle();
      prot_pin = 1;
      exp_latch = (nb != 32 || !v[1]) ? {7'd0, v[11]} : 8'd0;
      chk(rq, status[1], exp_latch[0]);
      if (v[0]) for (int i = 0; i < 32; i++) model[sec * 32 + i] = base + 8'(i);
      rd({sec, 5'd0}, d);  chk(rq, d, model[sec * 32]);
      rd({sec, 5'd31}, d); chk(rq, d, model[sec * 32 + 31]);
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule